// File: doc/BRIEF.md
# DMA Termination Interrupt Status Register

This block keeps a 16-bit record of why the most recent DMA transfers ended, for a packet-oriented DMA engine. Three sticky flags are kept. A stop flag records that a stop command reached the DMA command interface. An end-of-transfer flag and a transfer-complete flag are captured together on the command-execution strobe. Between them they tell software which of three endings took place: a short packet cut the transfer off early, the transfer finished on a short packet, or it finished cleanly with the counter at zero.

Software reads the flags through a small register port and clears any of them by writing 1 to its bit. A companion enable register sits behind the same port, selected by one address line. The interrupt output is a level that stays high while any set flag has its enable bit set. Hardware reset and bus reset both return every flag and every enable bit to 0.

Top module: `dma_term_irq_stat`

## Requirements
- R1: After `rst`, the status register and the enable register both read 0x0000 and `irq_o` is 0.
- R2: A cycle with `bus_rst_i` high clears every status flag and every enable bit. They read 0 on the next cycle and `irq_o` is 0.
- R3: A cycle with `stop_cmd_i` high sets status bit 12 (stop flag). The strobe is not needed for this.
- R4: A strobe cycle (`cmd_done_i` high) with `short_pkt_i` high and `cnt_zero_i` low sets bit 10 (end-of-transfer) and leaves bit 8 (transfer-complete) at 0.
- R5: A strobe cycle with `short_pkt_i` and `cnt_zero_i` both high sets bit 10 and bit 8.
- R6: A strobe cycle with `cnt_zero_i` high and `short_pkt_i` low sets bit 8 and leaves bit 10 at 0.
- R7: `short_pkt_i` and `cnt_zero_i` have no effect on the flags in a cycle where `cmd_done_i` is low.
- R8: A write with `reg_sel_i`=0 clears each status flag whose bit in `wr_data_i` is 1. Flags whose bit is 0 keep their value.
- R9: If a flag's set event and a software clear of that flag fall in the same cycle, the flag ends up set.
- R10: Bits 15..13, 11, 9 and 7..0 read 0 in both registers, whatever has been written to them.
- R11: `irq_o` is 1 exactly when some status flag and its enable bit (same bit position) are both 1. It holds that level over idle cycles until the enabled flags are cleared.
- R12: A write with `reg_sel_i`=1 loads the enable register. `rd_data_o` shows the status register when `reg_sel_i`=0 and the enable register when `reg_sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | Synchronous bus reset. Clears flags and enables |
| stop_cmd_i | input | 1 | Stop command pulse from the DMA command interface |
| short_pkt_i | input | 1 | A short packet was seen in the transfer |
| cnt_zero_i | input | 1 | The transfer counter has reached zero |
| cmd_done_i | input | 1 | Command-execution strobe that captures the termination flags |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench tries every combination of stop, short-packet, counter-zero and strobe inputs. A design that decoded the termination cases wrongly would show the end-of-transfer and complete bits in the wrong pairing. A design that sampled without the strobe would set flags from idle datapath signals. Every flag state is combined with every clear mask, which catches a clear that leaks into other bits or clears on a written 0. A set and a clear are issued in the same cycle, which exposes a design where the clear wins. Every enable pattern is tried against every flag state, with idle cycles before the check, which finds an interrupt that pulses instead of holding, ignores the enable, or stays high after its sources are cleared.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int REG_W    = 16;
    localparam int NFLAG    = 3;

    // bit positions software decodes
    localparam int STOP_BIT = 12;
    localparam int EOT_BIT  = 10;
    localparam int CMPL_BIT = 8;

    // index of each flag inside the internal flag vector
    localparam int IDX_CMPL = 0;
    localparam int IDX_EOT  = 1;
    localparam int IDX_STOP = 2;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic stop;
        logic short_pkt;
        logic cnt_zero;
        logic strobe;
    } dma_evt_t;

    typedef enum logic [1:0] {
        TERM_NONE,
        TERM_PREMATURE,
        TERM_SHORT_DONE,
        TERM_FULL_DONE
    } term_kind_e;

    function automatic term_kind_e classify(input dma_evt_t e);
        term_kind_e k;
        if (!e.strobe)
            k = TERM_NONE;
        else if (e.short_pkt && !e.cnt_zero)
            k = TERM_PREMATURE;
        else if (e.short_pkt && e.cnt_zero)
            k = TERM_SHORT_DONE;
        else if (e.cnt_zero)
            k = TERM_FULL_DONE;
        else
            k = TERM_NONE;
        return k;
    endfunction

    function automatic int flag_pos(input int idx);
        int p;
        case (idx)
            IDX_CMPL: p = CMPL_BIT;
            IDX_EOT:  p = EOT_BIT;
            default:  p = STOP_BIT;
        endcase
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pack_flags(input flag_vec_t f);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NFLAG; i++)
            w[flag_pos(i)] = f[i];
        return w;
    endfunction

    function automatic flag_vec_t unpack_flags(input logic [REG_W-1:0] w);
        flag_vec_t f;
        for (int i = 0; i < NFLAG; i++)
            f[i] = w[flag_pos(i)];
        return f;
    endfunction

endpackage

// File: rtl/dma_term_classifier.sv
module dma_term_classifier
    import dma_irq_pkg::*;
(
    input  dma_evt_t  evt_i,
    output flag_vec_t set_o
);
    term_kind_e kind;

    always_comb begin
        kind = classify(evt_i);
        set_o = '0;
        set_o[IDX_STOP] = evt_i.stop;
        unique case (kind)
            TERM_PREMATURE: set_o[IDX_EOT] = 1'b1;
            TERM_SHORT_DONE: begin
                set_o[IDX_EOT]  = 1'b1;
                set_o[IDX_CMPL] = 1'b1;
            end
            TERM_FULL_DONE: set_o[IDX_CMPL] = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_w1c_bank.sv
module dma_w1c_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clr_all_i)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;     // set has priority over clear
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_irq_enable_reg.sv
module dma_irq_enable_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_all_i)
            q_o <= '0;
        else if (wr_i)
            q_o <= wdata_i;
    end
endmodule

// File: rtl/dma_term_irq_stat.sv
module dma_term_irq_stat
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rst_i,
    input  logic             stop_cmd_i,
    input  logic             short_pkt_i,
    input  logic             cnt_zero_i,
    input  logic             cmd_done_i,
    input  logic             wr_en_i,
    input  logic             reg_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o
);
    dma_evt_t  evt;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t wr_flags;
    flag_vec_t stat_q;
    flag_vec_t en_q;

    always_comb begin
        evt.stop      = stop_cmd_i;
        evt.short_pkt = short_pkt_i;
        evt.cnt_zero  = cnt_zero_i;
        evt.strobe    = cmd_done_i;
        wr_flags      = unpack_flags(wr_data_i);
        clr_vec       = wr_flags & {NFLAG{wr_en_i && !reg_sel_i}};
    end

    dma_term_classifier u_cls (
        .evt_i (evt),
        .set_o (set_vec)
    );

    dma_w1c_bank #(.N(NFLAG)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .clr_all_i (bus_rst_i),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .q_o       (stat_q)
    );

    dma_irq_enable_reg #(.N(NFLAG)) u_en (
        .clk       (clk),
        .rst       (rst),
        .clr_all_i (bus_rst_i),
        .wr_i      (wr_en_i && reg_sel_i),
        .wdata_i   (wr_flags),
        .q_o       (en_q)
    );

    always_comb begin
        rd_data_o = pack_flags(reg_sel_i ? en_q : stat_q);
        irq_o     = |(stat_q & en_q);
    end
endmodule

// File: rtl/dma_term_irq_chk.sv
module dma_term_irq_chk
    import dma_irq_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bus_rst_i,
    input logic      stop_cmd_i,
    input logic      short_pkt_i,
    input logic      cnt_zero_i,
    input logic      cmd_done_i,
    input logic      wr_en_i,
    input logic      irq_o,
    input flag_vec_t stat_q,
    input flag_vec_t en_q
);
    a_r2_bus_clear: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> (stat_q == '0) && (en_q == '0));

    a_r3_stop_sets: assert property (@(posedge clk) disable iff (rst)
        (stop_cmd_i && !bus_rst_i) |=> stat_q[IDX_STOP]);

    a_r4_premature: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i && short_pkt_i && !cnt_zero_i && !bus_rst_i) |=> stat_q[IDX_EOT]);

    a_r6_cmpl_sets: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i && cnt_zero_i && !bus_rst_i) |=> stat_q[IDX_CMPL]);

    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !cmd_done_i |=> !$rose(stat_q[IDX_EOT]) && !$rose(stat_q[IDX_CMPL]));

    a_r11_irq_falls_on_write: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(wr_en_i || bus_rst_i));
endmodule

bind dma_term_irq_stat dma_term_irq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_rst_i   (bus_rst_i),
    .stop_cmd_i  (stop_cmd_i),
    .short_pkt_i (short_pkt_i),
    .cnt_zero_i  (cnt_zero_i),
    .cmd_done_i  (cmd_done_i),
    .wr_en_i     (wr_en_i),
    .irq_o       (irq_o),
    .stat_q      (stat_q),
    .en_q        (en_q)
);

// File: tb/dma_term_irq_stat_tb.sv
`timescale 1ns/1ps
module dma_term_irq_stat_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst_i = 1'b0;
    logic        stop_cmd_i = 1'b0;
    logic        short_pkt_i = 1'b0;
    logic        cnt_zero_i = 1'b0;
    logic        cmd_done_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_term_irq_stat dut_i (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i),
        .stop_cmd_i(stop_cmd_i), .short_pkt_i(short_pkt_i),
        .cnt_zero_i(cnt_zero_i), .cmd_done_i(cmd_done_i),
        .wr_en_i(wr_en_i), .reg_sel_i(reg_sel_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // flag code: bit2 stop(12), bit1 eot(10), bit0 complete(8)
    function automatic logic [15:0] expand(input int v);
        return (16'(v[2]) << 12) | (16'(v[1]) << 10) | (16'(v[0]) << 8);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs after a negedge, then return at the next negedge
    task automatic cyc(input logic stp, input logic shp, input logic zr, input logic stb,
                       input logic wr, input logic sel, input logic [15:0] d);
        stop_cmd_i = stp; short_pkt_i = shp; cnt_zero_i = zr; cmd_done_i = stb;
        wr_en_i = wr; reg_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        stop_cmd_i = 0; short_pkt_i = 0; cnt_zero_i = 0; cmd_done_i = 0;
        wr_en_i = 0; wr_data_i = 16'h0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        reg_sel_i = sel;
        #1;
        v = rd_data_o;
    endtask

    task automatic clear_stat();
        cyc(0, 0, 0, 0, 1, 0, 16'hFFFF);
    endtask

    // reach flag code st from a cleared register in one event cycle
    task automatic set_state(input int st);
        cyc(st[2], st[1], st[0], st[1] | st[0], 0, 0, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 status", v, 16'h0);
        rd(1, v); chk("R1 enable", v, 16'h0);
        chk("R1 irq", {15'h0, irq_o}, 16'h0);

        // R3..R7 sweep over every event combination
        for (int e = 0; e < 16; e++) begin
            logic [15:0] exp;
            string tag;
            clear_stat();
            cyc(e[3], e[2], e[1], e[0], 0, 0, 16'h0);
            exp = (16'(e[3]) << 12) | (16'(e[0] & e[2]) << 10) | (16'(e[0] & e[1]) << 8);
            if (!e[0]) tag = "R7/R3 no strobe";
            else if (e[2] && !e[1]) tag = "R4 premature";
            else if (e[2] && e[1]) tag = "R5 short done";
            else if (e[1]) tag = "R6 full done";
            else tag = "R3 strobe only";
            rd(0, v); chk(tag, v, exp);
        end

        // R8 every flag state against every clear mask
        for (int st = 0; st < 8; st++) begin
            for (int m = 0; m < 8; m++) begin
                clear_stat();
                set_state(st);
                cyc(0, 0, 0, 0, 1, 0, expand(m));
                rd(0, v); chk("R8 w1c", v, expand(st & ~m));
            end
        end

        // R9 set and clear in the same cycle
        clear_stat();
        cyc(1, 1, 0, 1, 1, 0, 16'h1400);
        rd(0, v); chk("R9 set wins", v, 16'h1400);
        clear_stat();
        cyc(0, 0, 1, 1, 1, 0, 16'h0100);
        rd(0, v); chk("R9 set wins cmpl", v, 16'h0100);

        // R10 / R12 reserved bits and register select
        cyc(0, 0, 0, 0, 1, 1, 16'hFFFF);
        rd(1, v); chk("R10 R12 enable readback", v, 16'h1500);
        clear_stat();
        set_state(7);
        cyc(0, 0, 0, 0, 1, 0, 16'hEAFF & 16'h0000);
        rd(0, v); chk("R10 status reserved", v, 16'h1500);
        cyc(0, 0, 0, 0, 1, 1, 16'hEAFF);
        rd(1, v); chk("R10 enable reserved write", v, 16'h0000);
        rd(0, v); chk("R12 status select", v, 16'h1500);

        // R11 every enable pattern against every flag state
        for (int en = 0; en < 8; en++) begin
            cyc(0, 0, 0, 0, 1, 1, expand(en) | 16'hE0F0);
            for (int st = 0; st < 8; st++) begin
                clear_stat();
                set_state(st);
                repeat (3) @(negedge clk);
                chk("R11 irq level", {15'h0, irq_o}, {15'h0, (st & en) != 0});
                cyc(0, 0, 0, 0, 1, 0, expand(st & en));
                chk("R11 irq after clear", {15'h0, irq_o}, 16'h0);
            end
        end

        // R2 bus reset
        cyc(0, 0, 0, 0, 1, 1, 16'h1500);
        clear_stat();
        set_state(7);
        chk("R2 irq before", {15'h0, irq_o}, 16'h1);
        bus_rst_i = 1;
        @(negedge clk);
        bus_rst_i = 0;
        rd(0, v); chk("R2 status", v, 16'h0);
        rd(1, v); chk("R2 enable", v, 16'h0);
        chk("R2 irq", {15'h0, irq_o}, 16'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule